// File: doc/BRIEF.md
# Periodic Systematic-and-Parity Puncturer

This block raises the code rate of a rate-1/3 turbo stream. Each information position delivers three bits at once: one systematic bit and two parity bits, one from each constituent encoder. Two runtime-programmable periodic masks decide which of these bits survive. The data mask governs the systematic bit. The parity mask governs both parity bits, and both parity streams use the same mask index. The surviving bits leave as a serial stream with a valid/ready handshake.

A position counter tracks the index inside the mask period. The period is 8 or 16, chosen by `long_sel`. The counter restarts on a triple that is marked as a frame start. Each accepted triple is placed in a one-entry holding stage, and a two-state machine drains it one kept bit per cycle. While the output is stalled, no new triple is accepted, so no bit is lost or sent twice.

State machine: `S_EMPTY` means the holding stage has no kept bits left and the block accepts input. `S_EMIT` means at least one kept bit is waiting. The transitions are:
- T_FILL: `S_EMPTY` to `S_EMIT` when a triple with a kept bit is accepted.
- T_SKIP: `S_EMPTY` to `S_EMPTY` when an accepted triple has every bit deleted.
- T_CHAIN: `S_EMIT` to `S_EMIT` when the last kept bit leaves and, in the same cycle, a new triple with a kept bit is accepted.
- T_DRAIN: `S_EMIT` to `S_EMPTY` when the last kept bit leaves and no new kept bit arrives.

Top module: `periodic_puncturer`

## Requirements
- R1: After reset, `out_valid` is 0, `in_ready` is 1, and the next triple accepted uses mask position 0.
- R2: Position p (counted from 0) uses bit p of `data_mask` for the systematic bit. A mask bit of 1 keeps the bit and 0 deletes it. The LSB therefore belongs to the first position of the period.
- R3: Both parity bits of position p are kept or deleted by bit p of `par_mask`. `in_par[0]` is parity 1 and `in_par[1]` is parity 2.
- R4: The kept bits of one position are emitted in the order systematic, parity 1, parity 2, followed by the kept bits of the next position.
- R5: With `long_sel`=0 the position wraps from 7 to 0, and mask bits 15..8 have no effect. With `long_sel`=1 it wraps from 15 to 0.
- R6: A triple accepted with `in_frame_start`=1 uses position 0, whatever the position was before. The following triple uses position 1.
- R7: While `out_valid`=1 and `out_ready`=0, the next cycle keeps `out_valid`=1 and the same `out_bit`. Across any pattern of stalls, the output stream equals the kept bits exactly, with no bit lost or duplicated.
- R8: A triple whose bits are all deleted is accepted, produces no output, and leaves `in_ready` at 1 when the block was empty.
- R9: `in_ready` is 1 whenever `out_valid` is 0, and also in the cycle where the last kept bit of the held triple is taken. This gives one triple per cycle when one bit is kept per position.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| long_sel | input | 1 | 0: period 8, 1: period 16 |
| data_mask | input | 16 | Systematic keep mask, bit p for position p |
| par_mask | input | 16 | Parity keep mask, bit p for position p |
| in_valid | input | 1 | Input triple present |
| in_ready | output | 1 | Triple accepted when in_valid and in_ready are both 1 |
| in_frame_start | input | 1 | Triple is the first of a frame (position 0) |
| in_sys | input | 1 | Systematic bit |
| in_par | input | 2 | Parity bits, [0] parity 1, [1] parity 2 |
| out_valid | output | 1 | Output bit present |
| out_ready | input | 1 | Downstream accepts the output bit |
| out_bit | output | 1 | Serialized kept bit |

## Verification
The two functions that can fall in the same cycle are the hand-off of the last kept bit of the held triple and the acceptance of the next triple (transition T_CHAIN). A T_CHAIN cycle is also where a lost or duplicated bit would appear. The bench provokes it by holding `out_ready` high under masks that keep one bit per position, so a new triple must enter on every cycle. It also runs random `out_ready` stalls and random `in_valid` gaps under denser masks. The result is judged by comparing every emitted bit against a queue of kept bits that the bench computes from the masks and its own position count, and by checking that `in_ready` stays high in the one-bit-per-position sweep.

// File: rtl/pp_pkg.sv
package pp_pkg;
    typedef enum logic {
        S_EMPTY = 1'b0,
        S_EMIT  = 1'b1
    } pp_state_e;
endpackage

// File: rtl/pp_pos_counter.sv
// Mask position tracker: returns the index for the current triple and
// advances it on acceptance, wrapping at the selected period.
module pp_pos_counter #(
    parameter int MAX_PERIOD   = 16,
    parameter int SHORT_PERIOD = 8,
    localparam int PW = $clog2(MAX_PERIOD)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          advance,
    input  logic          restart,
    input  logic          long_sel,
    output logic [PW-1:0] idx,
    output logic [PW-1:0] pos_q
);
    logic [PW-1:0] last_idx;

    assign last_idx = long_sel ? PW'(MAX_PERIOD - 1) : PW'(SHORT_PERIOD - 1);
    assign idx      = restart ? '0 : pos_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pos_q <= '0;
        end else if (advance) begin
            if (idx >= last_idx) pos_q <= '0;
            else                 pos_q <= idx + PW'(1);
        end
    end
endmodule

// File: rtl/pp_mask_pick.sv
// Builds the keep vector of one position: lane 0 systematic, lanes 1..NPAR parity.
module pp_mask_pick #(
    parameter int MAX_PERIOD = 16,
    parameter int NPAR       = 2,
    localparam int PW    = $clog2(MAX_PERIOD),
    localparam int NBITS = NPAR + 1
) (
    input  logic [MAX_PERIOD-1:0] data_mask,
    input  logic [MAX_PERIOD-1:0] par_mask,
    input  logic [PW-1:0]         idx,
    output logic [NBITS-1:0]      keep
);
    assign keep[0] = data_mask[idx];

    generate
        for (genvar g = 1; g < NBITS; g++) begin : g_par_lane
            assign keep[g] = par_mask[idx];
        end
    endgenerate
endmodule

// File: rtl/periodic_puncturer.sv
module periodic_puncturer #(
    parameter int MAX_PERIOD   = 16,
    parameter int SHORT_PERIOD = 8,
    parameter int NPAR         = 2,
    localparam int PW    = $clog2(MAX_PERIOD),
    localparam int NBITS = NPAR + 1,
    localparam int SW    = $clog2(NBITS)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  long_sel,
    input  logic [MAX_PERIOD-1:0] data_mask,
    input  logic [MAX_PERIOD-1:0] par_mask,
    input  logic                  in_valid,
    output logic                  in_ready,
    input  logic                  in_frame_start,
    input  logic                  in_sys,
    input  logic [NPAR-1:0]       in_par,
    output logic                  out_valid,
    input  logic                  out_ready,
    output logic                  out_bit
);
    import pp_pkg::*;

    pp_state_e        state_q, state_d;
    logic [NBITS-1:0] bits_q;
    logic [NBITS-1:0] keep_q;
    logic [NBITS-1:0] keep_new;
    logic [PW-1:0]    pos_idx;
    logic [PW-1:0]    pos_q;
    logic [SW-1:0]    sel;
    logic             accept;
    logic             take;
    logic             last_one;

    pp_pos_counter #(
        .MAX_PERIOD  (MAX_PERIOD),
        .SHORT_PERIOD(SHORT_PERIOD)
    ) u_pos (
        .clk     (clk),
        .rst_n   (rst_n),
        .advance (accept),
        .restart (in_frame_start),
        .long_sel(long_sel),
        .idx     (pos_idx),
        .pos_q   (pos_q)
    );

    pp_mask_pick #(
        .MAX_PERIOD(MAX_PERIOD),
        .NPAR      (NPAR)
    ) u_pick (
        .data_mask(data_mask),
        .par_mask (par_mask),
        .idx      (pos_idx),
        .keep     (keep_new)
    );

    // lowest pending lane goes out first: systematic, then parity in order
    always_comb begin
        sel = '0;
        for (int i = NBITS - 1; i >= 0; i--) begin
            if (keep_q[i]) sel = SW'(i);
        end
    end

    assign last_one = ($countones(keep_q) == 1);

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= S_EMPTY;
        else        state_q <= state_d;
    end

    // next state and outputs
    always_comb begin
        state_d   = state_q;
        out_valid = 1'b0;
        in_ready  = 1'b0;
        take      = 1'b0;
        unique case (state_q)
            S_EMPTY: begin
                in_ready = 1'b1;
                if (in_valid && (|keep_new)) state_d = S_EMIT;      // T_FILL
                // otherwise T_SKIP or idle
            end
            S_EMIT: begin
                out_valid = 1'b1;
                take      = out_ready;
                if (out_ready && last_one) begin
                    in_ready = 1'b1;
                    if (in_valid && (|keep_new)) state_d = S_EMIT;  // T_CHAIN
                    else                         state_d = S_EMPTY; // T_DRAIN
                end
            end
            default: state_d = S_EMPTY;
        endcase
    end

    assign accept  = in_valid && in_ready;
    assign out_bit = bits_q[sel];

    // holding stage
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bits_q <= '0;
            keep_q <= '0;
        end else if (accept) begin
            bits_q <= {in_par, in_sys};
            keep_q <= keep_new;
        end else if (take) begin
            keep_q <= keep_q & (keep_q - NBITS'(1));
        end
    end
endmodule

// File: rtl/periodic_puncturer_checker.sv
module periodic_puncturer_checker #(
    parameter int NBITS = 3
) (
    input logic             clk,
    input logic             rst_n,
    input logic             in_valid,
    input logic             in_ready,
    input logic             out_valid,
    input logic             out_ready,
    input logic             out_bit,
    input logic [NBITS-1:0] keep_new
);
    // R1: first cycle out of reset is empty and ready
    a_r1_reset_state: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_n && !$past(rst_n)) |-> (!out_valid && in_ready));

    // R7: a stalled bit is held unchanged
    a_r7_hold_bit: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_bit)));

    // R9: an empty stage always accepts
    a_r9_empty_ready: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> in_ready);

    // R8: an all-deleted triple into an empty stage produces nothing
    a_r8_skip_silent: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready && !out_valid && (keep_new == '0)) |=> !out_valid);
endmodule

bind periodic_puncturer periodic_puncturer_checker #(.NBITS(NBITS)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_valid (in_valid),
    .in_ready (in_ready),
    .out_valid(out_valid),
    .out_ready(out_ready),
    .out_bit  (out_bit),
    .keep_new (keep_new)
);

// File: tb/periodic_puncturer_bench.sv
module periodic_puncturer_bench;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        long_sel;
    logic [15:0] data_mask;
    logic [15:0] par_mask;
    logic        in_valid;
    logic        in_ready;
    logic        in_frame_start;
    logic        in_sys;
    logic [1:0]  in_par;
    logic        out_valid;
    logic        out_ready;
    logic        out_bit;

    int    n_tests = 0;
    int    n_fail  = 0;
    bit    done    = 0;
    string cur_req = "R1";
    bit    exp_q[$];
    int    tb_pos  = 0;
    bit    stall_prev = 0;
    bit    stall_bit  = 0;
    int    rdy_pct = 100;

    always #5 clk = ~clk;

    periodic_puncturer u_periodic_puncturer (
        .clk(clk), .rst_n(rst_n), .long_sel(long_sel),
        .data_mask(data_mask), .par_mask(par_mask),
        .in_valid(in_valid), .in_ready(in_ready), .in_frame_start(in_frame_start),
        .in_sys(in_sys), .in_par(in_par),
        .out_valid(out_valid), .out_ready(out_ready), .out_bit(out_bit)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // called #1 after the negedge, when inputs are driven and outputs settled
    task automatic observe();
        if (stall_prev) begin
            check(out_valid == 1'b1, "R7", int'(out_valid), 1);
            check(out_bit == stall_bit, "R7", int'(out_bit), int'(stall_bit));
        end
        if (out_valid && out_ready) begin
            if (exp_q.size() == 0) check(1'b0, cur_req, int'(out_bit), -1);
            else begin
                bit e;
                e = exp_q.pop_front();
                check(out_bit == e, cur_req, int'(out_bit), int'(e));
            end
        end
        if (in_valid && in_ready) begin
            int idx;
            int lastp;
            idx   = in_frame_start ? 0 : tb_pos;
            lastp = long_sel ? 15 : 7;
            if (data_mask[idx]) exp_q.push_back(in_sys);
            if (par_mask[idx])  exp_q.push_back(in_par[0]);
            if (par_mask[idx])  exp_q.push_back(in_par[1]);
            tb_pos = (idx >= lastp) ? 0 : idx + 1;
        end
        stall_prev = out_valid && !out_ready;
        stall_bit  = out_bit;
    endtask

    task automatic drive_ready();
        out_ready = (($urandom % 100) < rdy_pct);
    endtask

    // offer one triple until it is accepted
    task automatic send(input bit fs);
        bit s;
        bit [1:0] p;
        bit got;
        s = $urandom % 2;
        p = $urandom % 4;
        got = 0;
        while (!got) begin
            @(negedge clk);
            in_valid = 1'b1; in_frame_start = fs; in_sys = s; in_par = p;
            drive_ready();
            #1;
            got = in_ready;
            observe();
        end
        @(negedge clk);
        in_valid = 1'b0; in_frame_start = 1'b0;
        drive_ready();
        #1;
        observe();
    endtask

    task automatic drain(input string req);
        rdy_pct = 100;
        for (int k = 0; k < 64 && exp_q.size() != 0; k++) begin
            @(negedge clk);
            in_valid = 1'b0;
            drive_ready();
            #1;
            observe();
        end
        @(negedge clk);
        #1;
        observe();
        check(exp_q.size() == 0, req, exp_q.size(), 0);
        check(out_valid == 1'b0, req, int'(out_valid), 0);
    endtask

    task automatic run_masks(input bit ls, input logic [15:0] dm, input logic [15:0] pm,
                             input int n, input int pct, input string req);
        long_sel = ls; data_mask = dm; par_mask = pm; rdy_pct = pct; cur_req = req;
        for (int t = 0; t < n; t++) send(t == 0);
        drain(req);
    endtask

    initial begin
        rst_n = 1'b0; long_sel = 0; data_mask = '1; par_mask = '1;
        in_valid = 0; in_frame_start = 0; in_sys = 0; in_par = 0; out_ready = 1;
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;
        #1;
        // R1: reset state
        check(out_valid == 1'b0, "R1", int'(out_valid), 0);
        check(in_ready == 1'b1, "R1", int'(in_ready), 1);
        // R1: without frame start, first triple uses position 0 (only bit 0 kept)
        data_mask = 16'h0001; par_mask = 16'h0000; cur_req = "R1";
        send(1'b0);
        send(1'b0);
        drain("R1");

        // R9: one bit per position, continuous valid, ready high -> in_ready every cycle
        long_sel = 0; data_mask = 16'hFFFF; par_mask = 16'h0000; cur_req = "R9";
        rdy_pct = 100; tb_pos = 0;
        for (int t = 0; t < 20; t++) begin
            @(negedge clk);
            in_valid = 1; in_frame_start = (t == 0); in_sys = $urandom % 2; in_par = $urandom % 4;
            out_ready = 1;
            #1;
            if (t > 0) check(in_ready == 1'b1, "R9", int'(in_ready), 1);
            observe();
        end
        @(negedge clk); in_valid = 0; in_frame_start = 0; #1; observe();
        drain("R9");

        // R4: everything kept, order sys, p1, p2
        run_masks(0, 16'h00FF, 16'h00FF, 16, 100, "R4");
        // R3: parity only, both streams from the same mask bit
        run_masks(0, 16'h0000, 16'h0083, 32, 60, "R3");
        // R2: programmed mask pairs, with random stalls (R7 checked inside)
        run_masks(0, 16'h007E, 16'h0083, 40, 50, "R2");
        run_masks(0, 16'h00FF, 16'h0011, 40, 70, "R2");
        run_masks(0, 16'h0033, 16'h0099, 40, 40, "R2");
        // R5: period 16 and short period ignoring upper bits
        run_masks(1, 16'hFFFF, 16'h0005, 48, 60, "R5");
        run_masks(1, 16'h00FF, 16'h0F05, 48, 60, "R5");
        run_masks(0, 16'hFF0F, 16'hA500, 40, 60, "R5");
        // R6: frame starts at random points
        long_sel = 0; data_mask = 16'h0036; par_mask = 16'h0049; rdy_pct = 60; cur_req = "R6";
        for (int t = 0; t < 60; t++) send((t == 0) || (($urandom % 7) == 0));
        drain("R6");
        long_sel = 1; data_mask = 16'h1234; par_mask = 16'h8421;
        for (int t = 0; t < 60; t++) send((t == 0) || (($urandom % 5) == 0));
        drain("R6");

        // R8: all deleted, nothing comes out and input stays ready
        long_sel = 0; data_mask = 16'h0000; par_mask = 16'h0000; cur_req = "R8";
        for (int t = 0; t < 10; t++) begin
            @(negedge clk);
            in_valid = 1; in_frame_start = (t == 0); in_sys = 1; in_par = 2'b11; out_ready = 1;
            #1;
            check(in_ready == 1'b1, "R8", int'(in_ready), 1);
            check(out_valid == 1'b0, "R8", int'(out_valid), 0);
            observe();
        end
        @(negedge clk); in_valid = 0; #1; observe();
        check(out_valid == 1'b0, "R8", int'(out_valid), 0);
        drain("R8");

        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog %s actual=hung expected=finished", cur_req);
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule